// File: doc/BRIEF.md
# Dual-Half Registered Bidirectional Bus Transceiver

This block moves data between an A port and a B port in either direction. It is split into independent lanes, two 8-bit halves by default. Each lane has an active-low enable, a direction input, and two capture clocks. One clock stores the A-side pins and the other stores the B-side pins, each into its own register. For each direction, a select input chooses what the driven port carries: the live value from the other port, or the value held in the matching register. This lets a lane either pass data through or replay a word it stored earlier.

Port pins appear as separate input, output and output-enable vectors, one enable bit per data bit. Electrical effects are not modelled. The `GANG` parameter builds the variant in which lane 0's controls and clocks run every lane, so the block acts as one wide transceiver.

Top module: `bidir_store_xcvr`

## Requirements
- R1: For a lane with `oe_n` low, `dir` high sets every bit of that lane's `b_oe` to 1 and clears its `a_oe`. With `dir` low, every bit of `a_oe` is 1 and `b_oe` is clear.
- R2: While a lane's `oe_n` is high, that lane's `a_oe`, `b_oe`, `a_out` and `b_out` are all zero.
- R3: A rising edge of a lane's `clk_a2b` stores that lane's `a_in`, and a rising edge of `clk_b2a` stores its `b_in`. Capture happens whatever the enable, direction and select inputs are, so a word stored while the lane is disabled is the word recalled later.
- R4: When B is driven, `sel_a2b` = 0 puts the live `a_in` on `b_out`, and `sel_a2b` = 1 puts the stored A word on `b_out`.
- R5: When A is driven, `sel_b2a` = 0 puts the live `b_in` on `a_out`, and `sel_b2a` = 1 puts the stored B word on `a_out`.
- R6: When a select input changes, every bit of the driven output moves to the new source at once. No mixed or intermediate value appears.
- R7: A lane never asserts `a_oe` and `b_oe` together, and within a lane each enable vector is either all ones or all zeros.
- R8: A low `rst_n` clears both stored words at once, with no clock needed, and holds them at zero. Reset does not change the enables, which follow `oe_n` and `dir` alone.
- R9: With `GANG` = 0, one lane's control inputs, clocks and data do not affect the enables, outputs or stored words of any other lane.
- R10: With `GANG` = 1, lane 0's `oe_n`, `dir`, selects and clocks govern every lane, and the same inputs of the other lanes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the stored words |
| clk_a2b | input | N_LANES | Per-lane rising-edge capture of A-side pins |
| clk_b2a | input | N_LANES | Per-lane rising-edge capture of B-side pins |
| oe_n | input | N_LANES | Per-lane active-low output enable |
| dir | input | N_LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_a2b | input | N_LANES | Source for B: 0 live A, 1 stored A |
| sel_b2a | input | N_LANES | Source for A: 0 live B, 1 stored B |
| a_in | input | LANE_W*N_LANES | Values seen on the A pins |
| a_out | output | LANE_W*N_LANES | Value driven onto the A pins |
| a_oe | output | LANE_W*N_LANES | Per-bit drive enable of the A pins |
| b_in | input | LANE_W*N_LANES | Values seen on the B pins |
| b_out | output | LANE_W*N_LANES | Value driven onto the B pins |
| b_oe | output | LANE_W*N_LANES | Per-bit drive enable of the B pins |

## Verification
The hardest case to reach from the ports is a word captured while the lane was not driving that port: while disabled, while pointed the other way, or while in live mode. That word is then recalled with a different value already on the source pins. The vector table builds this case by pulsing a capture clock with the enable high or the direction reversed. It then turns the lane toward that port in stored mode while the source input holds an unrelated pattern. The clocked checker confirms that the recalled word matches the input seen at the previous capture edge. Directed steps then pull reset between clock edges, and exercise one lane while the other holds a stored word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef struct packed {
      logic oe_n;
      logic dir;
      logic sel_a2b;
      logic sel_b2a;
   } lane_ctl_t;

   typedef struct packed {
      logic drive_a;
      logic drive_b;
   } drive_t;

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
   import xcvr_pkg::*;
(
   input  lane_ctl_t ctl,
   output drive_t    drv
);

   // Both drive flags depend on the same enable, and dir selects exactly one of them.
   always_comb begin
      drv.drive_b = ~ctl.oe_n &  ctl.dir;
      drv.drive_a = ~ctl.oe_n & ~ctl.dir;
   end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
   parameter int WIDTH = 8
) (
   input  logic             sel_stored,
   input  logic             drive,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] picked;

   // The whole word switches source in one evaluation, so no bit-mixed value can appear.
   always_comb begin
      picked = sel_stored ? stored : live;
      dout   = drive ? picked : '0;
   end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic              rst_n,
   input  logic              clk_a2b,
   input  logic              clk_b2a,
   input  lane_ctl_t         ctl,
   input  logic [LANE_W-1:0] a_in,
   input  logic [LANE_W-1:0] b_in,
   output logic [LANE_W-1:0] a_out,
   output logic [LANE_W-1:0] a_oe,
   output logic [LANE_W-1:0] b_out,
   output logic [LANE_W-1:0] b_oe
);

   logic [LANE_W-1:0] a_word;
   logic [LANE_W-1:0] b_word;
   drive_t            drv;

   xcvr_store_reg #(.WIDTH(LANE_W)) u_store_a (
      .clk   (clk_a2b),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (a_word)
   );

   xcvr_store_reg #(.WIDTH(LANE_W)) u_store_b (
      .clk   (clk_b2a),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (b_word)
   );

   xcvr_drive_ctl u_drive (
      .ctl (ctl),
      .drv (drv)
   );

   xcvr_path_mux #(.WIDTH(LANE_W)) u_mux_to_b (
      .sel_stored (ctl.sel_a2b),
      .drive      (drv.drive_b),
      .live       (a_in),
      .stored     (a_word),
      .dout       (b_out)
   );

   xcvr_path_mux #(.WIDTH(LANE_W)) u_mux_to_a (
      .sel_stored (ctl.sel_b2a),
      .drive      (drv.drive_a),
      .live       (b_in),
      .stored     (b_word),
      .dout       (a_out)
   );

   assign a_oe = {LANE_W{drv.drive_a}};
   assign b_oe = {LANE_W{drv.drive_b}};

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr
   import xcvr_pkg::*;
#(
   parameter int  LANE_W  = 8,
   parameter int  N_LANES = 2,
   parameter bit  GANG    = 1'b0,
   localparam int BUS_W   = LANE_W * N_LANES
) (
   input  logic               rst_n,
   input  logic [N_LANES-1:0] clk_a2b,
   input  logic [N_LANES-1:0] clk_b2a,
   input  logic [N_LANES-1:0] oe_n,
   input  logic [N_LANES-1:0] dir,
   input  logic [N_LANES-1:0] sel_a2b,
   input  logic [N_LANES-1:0] sel_b2a,
   input  logic [BUS_W-1:0]   a_in,
   output logic [BUS_W-1:0]   a_out,
   output logic [BUS_W-1:0]   a_oe,
   input  logic [BUS_W-1:0]   b_in,
   output logic [BUS_W-1:0]   b_out,
   output logic [BUS_W-1:0]   b_oe
);

   if (LANE_W < 1) begin : g_bad_width
      $error("bidir_store_xcvr: LANE_W must be at least 1");
   end
   if (N_LANES < 1) begin : g_bad_lanes
      $error("bidir_store_xcvr: N_LANES must be at least 1");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      // Ganged build: every lane takes its controls and clocks from lane 0.
      localparam int CI = GANG ? 0 : i;
      lane_ctl_t ctl;

      assign ctl.oe_n    = oe_n[CI];
      assign ctl.dir     = dir[CI];
      assign ctl.sel_a2b = sel_a2b[CI];
      assign ctl.sel_b2a = sel_b2a[CI];

      xcvr_lane #(.LANE_W(LANE_W)) u_lane (
         .rst_n   (rst_n),
         .clk_a2b (clk_a2b[CI]),
         .clk_b2a (clk_b2a[CI]),
         .ctl     (ctl),
         .a_in    (a_in [i*LANE_W +: LANE_W]),
         .b_in    (b_in [i*LANE_W +: LANE_W]),
         .a_out   (a_out[i*LANE_W +: LANE_W]),
         .a_oe    (a_oe [i*LANE_W +: LANE_W]),
         .b_out   (b_out[i*LANE_W +: LANE_W]),
         .b_oe    (b_oe [i*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
   parameter int  LANE_W  = 8,
   parameter int  N_LANES = 2,
   parameter bit  GANG    = 1'b0,
   localparam int BUS_W   = LANE_W * N_LANES
) (
   input logic               rst_n,
   input logic [N_LANES-1:0] clk_a2b,
   input logic [N_LANES-1:0] clk_b2a,
   input logic [N_LANES-1:0] oe_n,
   input logic [N_LANES-1:0] sel_a2b,
   input logic [N_LANES-1:0] sel_b2a,
   input logic [BUS_W-1:0]   a_in,
   input logic [BUS_W-1:0]   b_in,
   input logic [BUS_W-1:0]   a_out,
   input logic [BUS_W-1:0]   a_oe,
   input logic [BUS_W-1:0]   b_out,
   input logic [BUS_W-1:0]   b_oe
);

   for (genvar i = 0; i < N_LANES; i++) begin : g_chk
      localparam int CI = GANG ? 0 : i;
      localparam int LO = i * LANE_W;
      logic armed_a;
      logic armed_b;

      always_ff @(posedge clk_a2b[CI] or negedge rst_n) begin
         if (!rst_n) armed_a <= 1'b0;
         else        armed_a <= 1'b1;
      end

      always_ff @(posedge clk_b2a[CI] or negedge rst_n) begin
         if (!rst_n) armed_b <= 1'b0;
         else        armed_b <= 1'b1;
      end

      // R7: both ports of a lane are never driven together
      p_oe_excl_a_r7: assert property (@(posedge clk_a2b[CI]) disable iff (!rst_n)
         (a_oe[LO +: LANE_W] & b_oe[LO +: LANE_W]) == '0);
      p_oe_excl_b_r7: assert property (@(posedge clk_b2a[CI]) disable iff (!rst_n)
         (a_oe[LO +: LANE_W] & b_oe[LO +: LANE_W]) == '0);

      // R2: a disabled lane drives nothing
      p_quiet_r2: assert property (@(posedge clk_a2b[CI]) disable iff (!rst_n)
         oe_n[CI] |-> (a_oe[LO +: LANE_W] == '0 && b_oe[LO +: LANE_W] == '0 &&
                       a_out[LO +: LANE_W] == '0 && b_out[LO +: LANE_W] == '0));

      // R4: stored mode on B replays A input seen at the previous capture edge
      p_recall_b_r4: assert property (@(posedge clk_a2b[CI]) disable iff (!rst_n)
         (armed_a && sel_a2b[CI] && b_oe[LO]) |->
            b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));

      // R5: stored mode on A replays B input seen at the previous capture edge
      p_recall_a_r5: assert property (@(posedge clk_b2a[CI]) disable iff (!rst_n)
         (armed_b && sel_b2a[CI] && a_oe[LO]) |->
            a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));
   end

endmodule

bind bidir_store_xcvr xcvr_checker #(
   .LANE_W  (LANE_W),
   .N_LANES (N_LANES),
   .GANG    (GANG)
) u_xcvr_checker (
   .rst_n   (rst_n),
   .clk_a2b (clk_a2b),
   .clk_b2a (clk_b2a),
   .oe_n    (oe_n),
   .sel_a2b (sel_a2b),
   .sel_b2a (sel_b2a),
   .a_in    (a_in),
   .b_in    (b_in),
   .a_out   (a_out),
   .a_oe    (a_oe),
   .b_out   (b_out),
   .b_oe    (b_oe)
);

// File: tb/tb_bidir_store_xcvr.sv
module tb_bidir_store_xcvr;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic        rst_n;
   logic [1:0]  ca, cb, oen, dir, sab, sba;
   logic [15:0] ain, bin;
   logic [15:0] aout, aoe, bout, boe;

   logic [1:0]  g_ca, g_cb, g_oen, g_dir, g_sab, g_sba;
   logic [15:0] g_ain, g_bin;
   logic [15:0] g_aout, g_aoe, g_bout, g_boe;

   bidir_store_xcvr dut (
      .rst_n(rst_n), .clk_a2b(ca), .clk_b2a(cb), .oe_n(oen), .dir(dir),
      .sel_a2b(sab), .sel_b2a(sba), .a_in(ain), .a_out(aout), .a_oe(aoe),
      .b_in(bin), .b_out(bout), .b_oe(boe));

   bidir_store_xcvr #(.GANG(1'b1)) dut_g (
      .rst_n(rst_n), .clk_a2b(g_ca), .clk_b2a(g_cb), .oe_n(g_oen), .dir(g_dir),
      .sel_a2b(g_sab), .sel_b2a(g_sba), .a_in(g_ain), .a_out(g_aout), .a_oe(g_aoe),
      .b_in(g_bin), .b_out(g_bout), .b_oe(g_boe));

   // {cap_a, cap_b, oe_n, dir, sel_a2b, sel_b2a, a_in, b_in,
   //  exp_a_oe, exp_b_oe, exp_a_out, exp_b_out, req}   lane 0 only
   localparam int NROW = 12;
   localparam logic [43:0] TBL [NROW] = '{
      {6'b000100, 8'h3C, 8'h00, 2'b01, 8'h00, 8'h3C, 4'd4},
      {6'b000100, 8'hA5, 8'h00, 2'b01, 8'h00, 8'hA5, 4'd4},
      {6'b000110, 8'hA5, 8'h00, 2'b01, 8'h00, 8'h00, 4'd4},
      {6'b101110, 8'h5A, 8'h00, 2'b00, 8'h00, 8'h00, 4'd2},
      {6'b000110, 8'hFF, 8'h00, 2'b01, 8'h00, 8'h5A, 4'd3},
      {6'b000000, 8'hFF, 8'h81, 2'b10, 8'h81, 8'h00, 4'd5},
      {6'b010000, 8'hFF, 8'h42, 2'b10, 8'h42, 8'h00, 4'd3},
      {6'b000001, 8'hFF, 8'h00, 2'b10, 8'h42, 8'h00, 4'd5},
      {6'b100001, 8'h77, 8'h00, 2'b10, 8'h42, 8'h00, 4'd3},
      {6'b000110, 8'h00, 8'h00, 2'b01, 8'h00, 8'h77, 4'd3},
      {6'b011001, 8'h00, 8'hE7, 2'b00, 8'h00, 8'h00, 4'd2},
      {6'b000001, 8'h00, 8'h00, 2'b10, 8'hE7, 8'h00, 4'd3}
   };

   function automatic string tag(input logic [3:0] n);
      case (n)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         default: return "R1";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      ca = '0; cb = '0; oen = 2'b11; dir = '0; sab = '0; sba = '0;
      ain = '0; bin = '0;
      g_ca = '0; g_cb = '0; g_oen = 2'b11; g_dir = '0; g_sab = '0; g_sba = '0;
      g_ain = '0; g_bin = '0;
      repeat (2) @(negedge clk);
      #1;
      chk("R2", "reset a_oe", aoe, 16'h0000);
      chk("R2", "reset b_out", bout, 16'h0000);

      // R8: enables follow oe_n/dir during reset; store held at zero despite a clock
      oen[0] = 1'b0; dir[0] = 1'b1; sab[0] = 1'b1; ain[7:0] = 8'hFF;
      @(posedge clk) ca[0] = 1'b1;
      @(negedge clk) ca[0] = 1'b0;
      #1;
      chk("R8", "b_oe in reset", boe, 16'h00FF);
      chk("R8", "b_out in reset", bout, 16'h0000);
      oen[0] = 1'b1;
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R2", "quiet after reset b_oe", boe, 16'h0000);

      // Vector table walk on lane 0
      for (int k = 0; k < NROW; k++) begin
         logic [43:0] e;
         e = TBL[k];
         @(negedge clk);
         oen[0] = e[41]; dir[0] = e[40]; sab[0] = e[39]; sba[0] = e[38];
         ain[7:0] = e[37:30]; bin[7:0] = e[29:22];
         if (e[43] || e[42]) begin
            @(posedge clk);
            ca[0] = e[43]; cb[0] = e[42];
            @(negedge clk);
            ca[0] = 1'b0; cb[0] = 1'b0;
         end
         #1;
         chk(tag(e[3:0]), $sformatf("row %0d a_oe", k), aoe[7:0], {8{e[21]}});
         chk(tag(e[3:0]), $sformatf("row %0d b_oe", k), boe[7:0], {8{e[20]}});
         chk(tag(e[3:0]), $sformatf("row %0d a_out", k), aout[7:0], e[19:12]);
         chk(tag(e[3:0]), $sformatf("row %0d b_out", k), bout[7:0], e[11:4]);
      end
      // stores now: lane0 A = 77, lane0 B = E7

      // R6: select flips move the whole word at once
      @(negedge clk);
      oen[0] = 1'b0; dir[0] = 1'b1; sab[0] = 1'b1; ain[7:0] = 8'h11;
      #1 chk("R6", "stored before flip", bout, 16'h0077);
      sab[0] = 1'b0;
      #1 chk("R6", "live right after flip", bout, 16'h0011);
      sab[0] = 1'b1;
      #1 chk("R6", "stored right after flip back", bout, 16'h0077);

      // R1/R7: sweep all control combinations of lane 0
      for (int c = 0; c < 16; c++) begin
         logic [7:0] ea, eb;
         @(negedge clk);
         {oen[0], dir[0], sab[0], sba[0]} = c[3:0];
         ea = (!c[3] && !c[2]) ? 8'hFF : 8'h00;
         eb = (!c[3] &&  c[2]) ? 8'hFF : 8'h00;
         #1;
         chk("R7", "no double drive", aoe[7:0] & boe[7:0], 16'h0000);
         chk("R1", "a_oe decode", aoe[7:0], {8'h00, ea});
         chk("R1", "b_oe decode", boe[7:0], {8'h00, eb});
      end

      // R9: lane 1 activity leaves lane 0 untouched
      @(negedge clk);
      oen[0] = 1'b0; dir[0] = 1'b1; sab[0] = 1'b1; ain[7:0] = 8'h44;
      oen[1] = 1'b0; dir[1] = 1'b0; sba[1] = 1'b0; bin[15:8] = 8'hC3;
      #1;
      chk("R9", "lane1 live to A", aout[15:8], 16'h00C3);
      chk("R9", "lane0 b_out kept", bout[7:0], 16'h0077);
      chk("R9", "lane0 a_oe clear", aoe[7:0], 16'h0000);
      ain[15:8] = 8'h9E;
      @(posedge clk) ca[1] = 1'b1;
      @(negedge clk) ca[1] = 1'b0;
      dir[1] = 1'b1; sab[1] = 1'b1; ain[15:8] = 8'h00;
      #1;
      chk("R9", "lane1 recalled", bout[15:8], 16'h009E);
      chk("R9", "lane0 store not clocked", bout[7:0], 16'h0077);

      // R8: asynchronous clear between clock edges
      #2 rst_n = 1'b0;
      #1;
      chk("R8", "async clear b_out", bout, 16'h0000);
      chk("R8", "enables kept in reset", boe, 16'hFFFF);
      @(negedge clk) rst_n = 1'b1;
      #1 chk("R8", "store still zero after release", bout, 16'h0000);

      // R10: ganged build follows lane 0 only
      @(negedge clk);
      g_oen = 2'b10; g_dir = 2'b01; g_sab = 2'b10; g_ain = 16'h1234;
      #1;
      chk("R10", "gang b_oe", g_boe, 16'hFFFF);
      chk("R10", "gang live", g_bout, 16'h1234);
      g_sab = 2'b01;
      @(posedge clk) g_ca = 2'b01;
      @(negedge clk) g_ca = 2'b00;
      g_ain = 16'h0000;
      #1 chk("R10", "gang stored both halves", g_bout, 16'h1234);
      g_ain = 16'hFFFF;
      @(posedge clk) g_ca = 2'b10;
      @(negedge clk) g_ca = 2'b00;
      #1 chk("R10", "lane1 clock ignored", g_bout, 16'h1234);

      finish_run();
   end

endmodule